// File: doc/BRIEF.md
# Parallel Wilkinson Multi-Cell Converter

This block is the digital half of a ramp-compare converter that digitizes many stored analog cells at the same time. One free-running counter drives the code of a ramp DAC. Every cell has its own comparator, which the block sees as one input bit per cell. Each cell's comparator watches the common ramp. The first time a cell's comparator level changes during a ramp, that cell captures the counter value. The captured value is the cell's conversion result.

A start pulse clears every cell and restarts the counter at zero. The ramp runs until the counter reaches full scale or until every cell has captured a code, whichever comes first. A one-cycle done pulse then marks the start of readout. The codes leave the block one per clock, lowest cell first, together with a valid strobe and an overflow flag for cells that never switched.

Top module: `wk_converter`

## Requirements
- R1: While reset (active-low `rstN`) is held and in the first cycle after it, `rampRun`, `convDone` and `rdValid` are 0 and `dacCode` is 0.
- R2: A `startPulse` seen while no ramp is running makes `rampRun` 1 in the next cycle with `dacCode` equal to 0. `dacCode` then rises by exactly 1 in every further cycle in which `rampRun` stays 1.
- R3: During a ramp, each cell captures the `dacCode` of the first cycle in which its comparator bit differs from the bit it had in the cycle before. The reference level for the first ramp cycle is the bit's value at the start edge.
- R4: After a cell has captured a code, further changes of its comparator bit within the same conversion leave its code unchanged.
- R5: A cell whose comparator has not changed by the cycle in which `dacCode` is full scale (all ones, 4095 at the default width) reads out as all ones with its overflow flag set to 1. A cell that changes in that very cycle also reads all ones, but with the flag at 0. In every other case the flag is 0.
- R6: The ramp ends after the cycle in which `dacCode` is full scale, or after the cycle in which the last uncaptured cell captures, whichever comes first. `rampRun` is 0 from the next cycle on, and `convDone` is 1 for exactly that one cycle.
- R7: Readout starts in the `convDone` cycle. `rdValid` is 1 for `NUM_CELLS` consecutive cycles, with `rdIndex` counting 0, 1, … `NUM_CELLS-1`. `rdCode` and `rdOverflow` belong to that index. Afterwards `rdValid` is 0.
- R8: A `startPulse` while `rampRun` is 1 is ignored. The ramp neither restarts nor ends early.
- R9: A `startPulse` during readout abandons the rest of the readout and starts a new ramp as in R2. All captured codes and overflow flags are cleared, so the next readout reflects only the new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to clear all cells and begin a new ramp |
| cmpIn | input | NUM_CELLS | Comparator output of each cell, bit i for cell i |
| rampRun | output | 1 | Ramp enable for the analog ramp generator |
| dacCode | output | CNT_W | Shared counter value, also the ramp DAC code |
| convDone | output | 1 | One-cycle pulse at the end of a conversion |
| rdValid | output | 1 | Readout data valid |
| rdIndex | output | $clog2(NUM_CELLS) | Cell number of the code being read out |
| rdCode | output | CNT_W | Captured code of cell `rdIndex` |
| rdOverflow | output | 1 | Cell `rdIndex` never switched before full scale |

## Verification
The bench builds the block with its defaults: eight cells and a 12-bit counter. With these values a full-scale ramp lasts 4096 cycles. That is short enough to run full-length conversions many times, so the overflow path and the full-scale boundary at code 4095 are reached repeatedly. Eight cells are enough for readout ordering, early completion once all cells have captured, and mixes of captured and overflowed cells to show up in one conversion. The comparator model adds one-count glitches after each crossing to test that only the first change is captured.

// File: rtl/wk_pkg.sv
package wk_pkg;

  // Strobes from the control unit to the per-cell datapath
  typedef struct packed {
    logic clear;   // start accepted: wipe every cell
    logic sample;  // ramp running: look for comparator changes
    logic atFull;  // counter sits at full scale this cycle
  } wkStrobe_t;

endpackage

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CNT_W     = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic                         allHit,
  output wkStrobe_t                    strobe,
  output logic                         rampRun,
  output logic [CNT_W-1:0]             dacCode,
  output logic                         convDone,
  output logic                         rdValid,
  output logic [$clog2(NUM_CELLS)-1:0] rdIndex
);

  localparam int IDX_W = $clog2(NUM_CELLS);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CELLS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_READ} wkState_t;

  wkState_t         state;
  logic [CNT_W-1:0] rampCnt;
  logic [IDX_W-1:0] readIdx;
  logic             donePulse;
  logic             convEnd;

  always_comb begin
    strobe.clear  = startPulse && (state != ST_CONV);
    strobe.sample = (state == ST_CONV);
    strobe.atFull = (state == ST_CONV) && (rampCnt == CNT_MAX);
    convEnd       = strobe.sample && (allHit || (rampCnt == CNT_MAX));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rampCnt   <= '0;
      readIdx   <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= convEnd;
      if (strobe.clear) begin
        state   <= ST_CONV;
        rampCnt <= '0;
        readIdx <= '0;
      end else begin
        case (state)
          ST_CONV: begin
            if (convEnd) begin
              state   <= ST_READ;
              readIdx <= '0;
            end else begin
              rampCnt <= rampCnt + 1'b1;
            end
          end
          ST_READ: begin
            if (readIdx == LAST_IDX) state <= ST_IDLE;
            else readIdx <= readIdx + 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rampRun  = (state == ST_CONV);
  assign rdValid  = (state == ST_READ);
  assign dacCode  = rampCnt;
  assign convDone = donePulse;
  assign rdIndex  = readIdx;

endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CNT_W     = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wkStrobe_t                    strobe,
  input  logic [NUM_CELLS-1:0]         cmpIn,
  input  logic [CNT_W-1:0]             dacCode,
  input  logic [$clog2(NUM_CELLS)-1:0] rdIndex,
  output logic                         allHit,
  output logic [CNT_W-1:0]             rdCode,
  output logic                         rdOverflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CELLS-1:0]            hitNow;
  logic [NUM_CELLS-1:0]            hitVec;
  logic [NUM_CELLS-1:0]            ovfVec;
  logic [NUM_CELLS-1:0][CNT_W-1:0] codeVec;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic             prevLvl;
    logic             hitFlag;
    logic             ovfFlag;
    logic [CNT_W-1:0] cellCode;

    // first level change since the ramp began
    assign hitNow[c] = strobe.sample && !hitFlag && (cmpIn[c] != prevLvl);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevLvl  <= 1'b0;
        hitFlag  <= 1'b0;
        ovfFlag  <= 1'b0;
        cellCode <= '0;
      end else if (strobe.clear) begin
        prevLvl  <= cmpIn[c];
        hitFlag  <= 1'b0;
        ovfFlag  <= 1'b0;
        cellCode <= '0;
      end else if (strobe.sample) begin
        prevLvl <= cmpIn[c];
        if (hitNow[c]) begin
          hitFlag  <= 1'b1;
          cellCode <= dacCode;
        end else if (strobe.atFull && !hitFlag) begin
          ovfFlag  <= 1'b1;
          cellCode <= CNT_MAX;
        end
      end
    end

    assign hitVec[c]  = hitFlag;
    assign ovfVec[c]  = ovfFlag;
    assign codeVec[c] = cellCode;
  end

  assign allHit     = &(hitVec | hitNow);
  assign rdCode     = codeVec[rdIndex];
  assign rdOverflow = ovfVec[rdIndex];

endmodule

// File: rtl/wk_converter.sv
module wk_converter
  import wk_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CNT_W     = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic [NUM_CELLS-1:0]         cmpIn,
  output logic                         rampRun,
  output logic [CNT_W-1:0]             dacCode,
  output logic                         convDone,
  output logic                         rdValid,
  output logic [$clog2(NUM_CELLS)-1:0] rdIndex,
  output logic [CNT_W-1:0]             rdCode,
  output logic                         rdOverflow
);

  wkStrobe_t strobe;
  logic      allHit;

  wk_ctrl #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .allHit     (allHit),
    .strobe     (strobe),
    .rampRun    (rampRun),
    .dacCode    (dacCode),
    .convDone   (convDone),
    .rdValid    (rdValid),
    .rdIndex    (rdIndex)
  );

  wk_datapath #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpIn      (cmpIn),
    .dacCode    (dacCode),
    .rdIndex    (rdIndex),
    .allHit     (allHit),
    .rdCode     (rdCode),
    .rdOverflow (rdOverflow)
  );

endmodule

// File: rtl/wk_converter_chk.sv
module wk_converter_chk #(
  parameter int NUM_CELLS = 8,
  parameter int CNT_W     = 12
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         startPulse,
  input logic                         rampRun,
  input logic [CNT_W-1:0]             dacCode,
  input logic                         convDone,
  input logic                         rdValid,
  input logic [$clog2(NUM_CELLS)-1:0] rdIndex,
  input logic [CNT_W-1:0]             rdCode,
  input logic                         rdOverflow
);

  // R2
  ramp_start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampRun) |-> dacCode == '0);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rampRun && $past(rampRun)) |-> dacCode == $past(dacCode) + 1'b1);

  // R5
  ovf_code_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdOverflow) |-> rdCode == {CNT_W{1'b1}});

  // R6
  done_after_ramp_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> ($past(rampRun) && !rampRun));

  // R7
  done_first_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (rdValid && rdIndex == '0));

  // R7
  read_index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |-> rdIndex == $past(rdIndex) + 1'b1);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rampRun && $past(rampRun) && startPulse) |=> dacCode != '0);

  // R7
  read_ramp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && rampRun));

endmodule

bind wk_converter wk_converter_chk #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W)) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .rampRun    (rampRun),
  .dacCode    (dacCode),
  .convDone   (convDone),
  .rdValid    (rdValid),
  .rdIndex    (rdIndex),
  .rdCode     (rdCode),
  .rdOverflow (rdOverflow)
);

// File: tb/tb_wk_converter.sv
module tb_wk_converter;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int W          = 12;
  localparam int FULL       = (1 << W) - 1;
  localparam int NEVER      = FULL + 1000;
  localparam int IW         = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [N-1:0]  cmpIn;
  logic          rampRun;
  logic [W-1:0]  dacCode;
  logic          convDone;
  logic          rdValid;
  logic [IW-1:0] rdIndex;
  logic [W-1:0]  rdCode;
  logic          rdOverflow;

  int thr [N];
  bit noisy [N];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // analog model: comparator flips once the ramp passes the stored level,
  // with an optional one-count glitch two counts after the crossing
  always_comb begin
    for (int i = 0; i < N; i++)
      cmpIn[i] = rampRun && (int'(dacCode) >= thr[i]) &&
                 !(noisy[i] && int'(dacCode) == thr[i] + 2);
  end

  wk_converter #(.NUM_CELLS(N), .CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpIn(cmpIn),
    .rampRun(rampRun), .dacCode(dacCode), .convDone(convDone),
    .rdValid(rdValid), .rdIndex(rdIndex), .rdCode(rdCode),
    .rdOverflow(rdOverflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expCode(input int t);
    return (t > FULL) ? FULL : t;
  endfunction

  function automatic int expRun();
    int m = 0;
    for (int i = 0; i < N; i++) begin
      if (thr[i] > FULL) return FULL + 1;
      if (thr[i] > m) m = thr[i];
    end
    return m + 1;
  endfunction

  // Runs one conversion. skipStart: start already issued (abort path).
  // midStart: ramp cycle in which a stray start is pulsed (-1 none).
  // abortAt: readout index at which a new start is issued (-1 none).
  task automatic runConv(input string tag, input bit skipStart,
                         input int midStart, input int abortAt);
    int runLen;
    int expLen;
    expLen = expRun();
    if (!skipStart) begin
      @(negedge clk) startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
    end
    chk(rampRun == 1'b1, "R2", {tag, " ramp on after start"}, int'(rampRun), 1);
    chk(dacCode == '0, "R2", {tag, " ramp code starts at 0"}, int'(dacCode), 0);
    runLen = 1;
    forever begin
      startPulse = (runLen == midStart);
      @(negedge clk);
      startPulse = 1'b0;
      if (!rampRun) break;
      runLen++;
    end
    chk(runLen == expLen, midStart >= 0 ? "R8" : "R6",
        {tag, " ramp length"}, runLen, expLen);
    chk(convDone == 1'b1, "R6", {tag, " done pulse"}, int'(convDone), 1);
    for (int k = 0; k < N; k++) begin
      if (k == abortAt) begin
        startPulse = 1'b1;
        @(negedge clk) startPulse = 1'b0;
        chk(rampRun && dacCode == '0, "R9", {tag, " restart from readout"},
            int'(rampRun), 1);
        return;
      end
      chk(rdValid && int'(rdIndex) == k, "R7", {tag, " readout index"},
          rdValid ? int'(rdIndex) : -1, k);
      chk(int'(rdCode) == expCode(thr[k]), thr[k] > FULL ? "R5" : "R3",
          {tag, " code"}, int'(rdCode), expCode(thr[k]));
      chk(rdOverflow == (thr[k] > FULL), "R5", {tag, " overflow flag"},
          int'(rdOverflow), int'(thr[k] > FULL));
      if (k == 1)
        chk(convDone == 1'b0, "R6", {tag, " done is one cycle"}, int'(convDone), 0);
      @(negedge clk);
    end
    chk(rdValid == 1'b0, "R7", {tag, " valid drops after last cell"}, int'(rdValid), 0);
  endtask

  task automatic setAll(input int t, input bit nz);
    for (int i = 0; i < N; i++) begin
      thr[i] = t;
      noisy[i] = nz;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    int pick [N] = '{5, 100, 0, 4095, 37, 2000, 1, 800};
    void'($urandom(32'd4711));
    setAll(NEVER, 1'b0);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!rampRun && !convDone && !rdValid && dacCode == '0, "R1",
        "outputs in reset", int'(rampRun), 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    chk(!rampRun && !convDone && !rdValid && dacCode == '0, "R1",
        "outputs after reset", int'(dacCode), 0);

    // directed: spread of thresholds including 0 and full scale (R3, R5)
    for (int i = 0; i < N; i++) begin thr[i] = pick[i]; noisy[i] = 1'b0; end
    runConv("spread", 1'b0, -1, -1);

    // every cell overflows (R5, R6)
    setAll(NEVER, 1'b0);
    runConv("allOvf", 1'b0, -1, -1);

    // early end when all cells agree (R6)
    setAll(10, 1'b0);
    runConv("early", 1'b0, -1, -1);

    // glitches after the crossing are ignored (R4)
    for (int i = 0; i < N; i++) begin thr[i] = 20 + 30 * i; noisy[i] = 1'b1; end
    runConv("R4 noise", 1'b0, -1, -1);

    // stray start during ramp (R8)
    for (int i = 0; i < N; i++) begin thr[i] = 300 - 11 * i; noisy[i] = 1'b0; end
    runConv("midStart", 1'b0, 50, -1);

    // abort readout of a half-overflowed conversion, then clean one (R9)
    for (int i = 0; i < N; i++) begin thr[i] = (i % 2) ? NEVER : 60 + i; noisy[i] = 1'b0; end
    runConv("preAbort", 1'b0, -1, 3);
    for (int i = 0; i < N; i++) begin thr[i] = 7 * i + 2; noisy[i] = 1'b0; end
    runConv("R9 fresh", 1'b1, -1, -1);

    // constrained random
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < N; i++) begin
        thr[i]   = ($urandom % 16 == 0) ? NEVER : int'($urandom % (FULL + 1));
        noisy[i] = bit'($urandom % 2);
      end
      runConv($sformatf("rand%0d", r), 1'b0, -1, -1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule